// File: doc/BRIEF.md
# Segment Table Translation Unit

This block maps a logical address, made of a segment number and an offset inside that segment, onto a physical address. A small segment table lives in internal registers. Each slot carries a physical base, a segment length (limit), a validity flag and three permission flags for read, write and execute. A separate count register states how many segments are currently in use.

A request presents the segment number, the offset and the access type for one cycle. One clock edge later the block shows either the physical address (base plus offset) or a fault code, and it keeps that result until the next request arrives. Table slots and the count register can be written only while the privileged-mode input is high. Software in privileged mode is expected to fill the table before user accesses start.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table slot and the segment count are zero, `done_o`, `fault_o` and `pa_o` are zero, and the first request faults with code 1 (segment out of range).
- R2: A request whose segment number is greater than or equal to the segment count returns fault code 1.
- R3: A request to a slot whose validity flag is 0 returns fault code 2.
- R4: A request whose offset is greater than or equal to the slot's limit returns fault code 3. A limit of 0 faults every offset, and offset limit-1 is legal.
- R5: A request whose access type is not permitted returns fault code 4. The access type encodes 0 = read (permission bit 0), 1 = write (bit 1), 2 = execute (bit 2), and 3 is reserved and always denied.
- R6: A request that passes every check returns fault code 0 and `pa_o` = base + offset, modulo 2^PA_W. Whenever the fault code is nonzero, `pa_o` is 0.
- R7: When several checks fail, the reported code follows this priority: segment range (1), then validity (2), then limit (3), then permission (4).
- R8: Writes to a table slot or to the segment count take effect on the clock edge only when `priv_i` is high. With `priv_i` low they are ignored.
- R9: `done_o` is high for exactly the cycle after a request cycle, and `pa_o` and `fault_o` stay unchanged in every cycle that follows a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | Privileged mode; enables table writes |
| wr_entry_i | input | 1 | Write one table slot |
| wr_len_i | input | 1 | Write the segment count |
| wr_idx_i | input | SEG_W | Slot index for a slot write |
| wr_base_i | input | PA_W | Physical base to store |
| wr_limit_i | input | OFF_W+1 | Segment length to store |
| wr_valid_i | input | 1 | Validity flag to store |
| wr_perm_i | input | 3 | Permission flags {exec, write, read} to store |
| wr_len_val_i | input | SEG_W+1 | New segment count |
| req_i | input | 1 | Translation request |
| seg_i | input | SEG_W | Requested segment number |
| off_i | input | OFF_W | Requested offset |
| acc_i | input | 2 | Access type (0 read, 1 write, 2 exec, 3 reserved) |
| done_o | output | 1 | Result valid, one cycle after a request |
| fault_o | output | 3 | Fault code (0 none, 1 range, 2 invalid, 3 limit, 4 permission) |
| pa_o | output | PA_W | Physical address, zero on a fault |

## Verification
The assertions assume that `req_i` and table writes never fall in the same cycle, so the slot being checked cannot change under a request. The bench keeps to this because it runs loads and translations in separate tasks, each driving its inputs at the falling edge and releasing them at the next one. The assertions also assume that the reset is applied before the first request. The bench issues a single request right after reset to check the empty table, and does not load the table until after that request.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int PERM_W = 3;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_SEG  = 3'd1,
    FLT_INV  = 3'd2,
    FLT_LIM  = 3'd3,
    FLT_PERM = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;
endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int LIM_W = 9,
  parameter int PA_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              priv_i,
  input  logic              wr_entry_i,
  input  logic              wr_len_i,
  input  logic [SEG_W-1:0]  wr_idx_i,
  input  logic [PA_W-1:0]   wr_base_i,
  input  logic [LIM_W-1:0]  wr_limit_i,
  input  logic              wr_valid_i,
  input  logic [PERM_W-1:0] wr_perm_i,
  input  logic [SEG_W:0]    wr_len_val_i,
  input  logic [SEG_W-1:0]  rd_idx_i,
  output logic [PA_W-1:0]   rd_base_o,
  output logic [LIM_W-1:0]  rd_limit_o,
  output logic              rd_valid_o,
  output logic [PERM_W-1:0] rd_perm_o,
  output logic [SEG_W:0]    len_o
);
  localparam int NUM_SEG = 1 << SEG_W;

  logic [PA_W-1:0]   base_q  [NUM_SEG];
  logic [LIM_W-1:0]  limit_q [NUM_SEG];
  logic              valid_q [NUM_SEG];
  logic [PERM_W-1:0] perm_q  [NUM_SEG];
  logic [SEG_W:0]    len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                len_q <= '0;
    else if (priv_i && wr_len_i) len_q <= wr_len_val_i;
  end

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_slot
    logic hit;
    assign hit = priv_i && wr_entry_i && (wr_idx_i == SEG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        valid_q[g] <= 1'b0;
        perm_q[g]  <= '0;
      end else if (hit) begin
        base_q[g]  <= wr_base_i;
        limit_q[g] <= wr_limit_i;
        valid_q[g] <= wr_valid_i;
        perm_q[g]  <= wr_perm_i;
      end
    end

    // R8: unprivileged cycles leave the slot untouched
    a_r8_slot_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !priv_i |=> ($stable(base_q[g]) && $stable(limit_q[g]) &&
                   $stable(valid_q[g]) && $stable(perm_q[g])));
  end

  assign rd_base_o  = base_q[rd_idx_i];
  assign rd_limit_o = limit_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_perm_o  = perm_q[rd_idx_i];
  assign len_o      = len_q;

  a_r8_len_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !priv_i |=> $stable(len_q));
endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 8,
  parameter int LIM_W = 9,
  parameter int PA_W  = 12
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        acc_i,
  input  logic [SEG_W:0]    len_i,
  input  logic [PA_W-1:0]   base_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic              valid_i,
  input  logic [PERM_W-1:0] perm_i,
  output fault_e            fault_o,
  output logic [PA_W-1:0]   pa_o
);
  logic seg_bad, lim_bad, perm_ok;

  assign seg_bad = {1'b0, seg_i} >= len_i;
  assign lim_bad = LIM_W'(off_i) >= limit_i;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_RD:  perm_ok = perm_i[0];
      ACC_WR:  perm_ok = perm_i[1];
      ACC_EX:  perm_ok = perm_i[2];
      default: perm_ok = 1'b0;
    endcase
  end

  // priority: range, valid, limit, permission
  always_comb begin
    if (seg_bad)       fault_o = FLT_SEG;
    else if (!valid_i) fault_o = FLT_INV;
    else if (lim_bad)  fault_o = FLT_LIM;
    else if (!perm_ok) fault_o = FLT_PERM;
    else               fault_o = FLT_NONE;
  end

  assign pa_o = (fault_o == FLT_NONE) ? base_i + PA_W'(off_i) : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int OFF_W = 8,
  parameter int PA_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               priv_i,
  input  logic               wr_entry_i,
  input  logic               wr_len_i,
  input  logic [SEG_W-1:0]   wr_idx_i,
  input  logic [PA_W-1:0]    wr_base_i,
  input  logic [OFF_W:0]     wr_limit_i,
  input  logic               wr_valid_i,
  input  logic [2:0]         wr_perm_i,
  input  logic [SEG_W:0]     wr_len_val_i,
  input  logic               req_i,
  input  logic [SEG_W-1:0]   seg_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [1:0]         acc_i,
  output logic               done_o,
  output logic [2:0]         fault_o,
  output logic [PA_W-1:0]    pa_o
);
  localparam int LIM_W = OFF_W + 1;

  logic [PA_W-1:0]   ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic              ent_valid;
  logic [PERM_W-1:0] ent_perm;
  logic [SEG_W:0]    seg_len;
  fault_e            chk_fault;
  logic [PA_W-1:0]   chk_pa;

  seg_xlate_table #(.SEG_W(SEG_W), .LIM_W(LIM_W), .PA_W(PA_W)) i_table (
    .clk_i, .rst_ni, .priv_i, .wr_entry_i, .wr_len_i, .wr_idx_i,
    .wr_base_i, .wr_limit_i, .wr_valid_i, .wr_perm_i, .wr_len_val_i,
    .rd_idx_i   (seg_i),
    .rd_base_o  (ent_base),
    .rd_limit_o (ent_limit),
    .rd_valid_o (ent_valid),
    .rd_perm_o  (ent_perm),
    .len_o      (seg_len)
  );

  seg_xlate_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .LIM_W(LIM_W), .PA_W(PA_W)) i_check (
    .seg_i, .off_i, .acc_i,
    .len_i   (seg_len),
    .base_i  (ent_base),
    .limit_i (ent_limit),
    .valid_i (ent_valid),
    .perm_i  (ent_perm),
    .fault_o (chk_fault),
    .pa_o    (chk_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      fault_o <= '0;
      pa_o    <= '0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        fault_o <= chk_fault;
        pa_o    <= chk_pa;
      end
    end
  end

  a_r9_done_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  a_r9_no_spurious_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o);
  a_r9_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(pa_o) && $stable(fault_o)));
  a_r2_seg_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ({1'b0, seg_i} >= seg_len)) |=> (fault_o == 3'd1));
  a_r6_pa_zero_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o != 3'd0) |-> (pa_o == '0));
  a_r7_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o <= 3'd4);
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W = 3;
  localparam int OFF_W = 8;
  localparam int PA_W  = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic priv_i = 1'b0, wr_entry_i = 1'b0, wr_len_i = 1'b0;
  logic [SEG_W-1:0] wr_idx_i = '0;
  logic [PA_W-1:0]  wr_base_i = '0;
  logic [OFF_W:0]   wr_limit_i = '0;
  logic             wr_valid_i = 1'b0;
  logic [2:0]       wr_perm_i = '0;
  logic [SEG_W:0]   wr_len_val_i = '0;
  logic             req_i = 1'b0;
  logic [SEG_W-1:0] seg_i = '0;
  logic [OFF_W-1:0] off_i = '0;
  logic [1:0]       acc_i = '0;
  logic             done_o;
  logic [2:0]       fault_o;
  logic [PA_W-1:0]  pa_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_seg_xlate (
    .clk_i(clk), .rst_ni, .priv_i, .wr_entry_i, .wr_len_i, .wr_idx_i,
    .wr_base_i, .wr_limit_i, .wr_valid_i, .wr_perm_i, .wr_len_val_i,
    .req_i, .seg_i, .off_i, .acc_i, .done_o, .fault_o, .pa_o
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load_entry(int idx, int base, int lim, bit vld, int perm, bit priv);
    @(negedge clk);
    priv_i = priv; wr_entry_i = 1'b1; wr_idx_i = SEG_W'(idx);
    wr_base_i = PA_W'(base); wr_limit_i = (OFF_W+1)'(lim);
    wr_valid_i = vld; wr_perm_i = 3'(perm);
    @(negedge clk);
    wr_entry_i = 1'b0; priv_i = 1'b0;
  endtask

  task automatic load_len(int n, bit priv);
    @(negedge clk);
    priv_i = priv; wr_len_i = 1'b1; wr_len_val_i = (SEG_W+1)'(n);
    @(negedge clk);
    wr_len_i = 1'b0; priv_i = 1'b0;
  endtask

  task automatic xlate(string req, int seg, int off, int acc, int exp_flt, int exp_pa);
    @(negedge clk);
    req_i = 1'b1; seg_i = SEG_W'(seg); off_i = OFF_W'(off); acc_i = 2'(acc);
    @(negedge clk);
    req_i = 1'b0;
    check({req, " done"}, int'(done_o), 1);
    check({req, " fault"}, int'(fault_o), exp_flt);
    check({req, " pa"}, int'(pa_o), exp_pa);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 done", int'(done_o), 0);
    check("R1 fault", int'(fault_o), 0);
    check("R1 pa", int'(pa_o), 0);
    rst_ni = 1'b1;
    xlate("R1 empty table", 0, 0, 0, 1, 0);
  endtask

  task automatic t_setup;
    load_entry(0, 'h100, 'h40, 1, 3'b101, 1);
    load_entry(1, 'hFF0, 'h100, 1, 3'b011, 1);
    load_entry(2, 'h200, 'h10, 0, 3'b111, 1);
    load_entry(3, 'h300, 0, 1, 3'b111, 1);
    load_entry(5, 'h500, 'h10, 1, 3'b001, 1);
    load_len(4, 1);
  endtask

  task automatic t_pass;
    xlate("R6 seg0 rd top", 0, 'h3F, 0, 0, 'h13F);
    xlate("R6 seg0 ex", 0, 5, 2, 0, 'h105);
    xlate("R6 seg1 wr wrap", 1, 'h20, 1, 0, 'h010);
    xlate("R6 seg1 rd max off", 1, 'hFF, 0, 0, 'h0EF);
  endtask

  task automatic t_faults;
    xlate("R4 seg0 off=limit", 0, 'h40, 0, 3, 0);
    xlate("R4 seg3 zero limit", 3, 0, 0, 3, 0);
    xlate("R5 seg0 wr denied", 0, 1, 1, 4, 0);
    xlate("R5 seg1 ex denied", 1, 1, 2, 4, 0);
    xlate("R5 reserved acc", 1, 1, 3, 4, 0);
    xlate("R3 seg2 invalid", 2, 0, 0, 2, 0);
    xlate("R2 seg4 = len", 4, 0, 0, 1, 0);
    xlate("R2 seg5 loaded but beyond len", 5, 0, 0, 1, 0);
    xlate("R2 seg7", 7, 0, 0, 1, 0);
  endtask

  task automatic t_priority;
    load_entry(2, 'h200, 'h10, 0, 3'b000, 1);
    xlate("R7 invalid over limit+perm", 2, 'h20, 1, 2, 0);
    xlate("R7 limit over perm", 0, 'h50, 1, 3, 0);
    xlate("R7 range over invalid", 6, 'hFF, 3, 1, 0);
  endtask

  task automatic t_priv;
    load_entry(0, 'h700, 'h40, 1, 3'b101, 0);
    xlate("R8 unpriv slot write ignored", 0, 1, 0, 0, 'h101);
    load_len(0, 0);
    xlate("R8 unpriv len write ignored", 0, 2, 0, 0, 'h102);
    load_len(8, 1);
    xlate("R8 priv len write", 5, 3, 0, 0, 'h503);
  endtask

  task automatic t_hold;
    xlate("R9 setup", 1, 4, 1, 0, 'hFF4);
    repeat (3) begin
      @(negedge clk);
      check("R9 done idle", int'(done_o), 0);
      check("R9 pa held", int'(pa_o), 'hFF4);
      check("R9 fault held", int'(fault_o), 0);
    end
    xlate("R9 next request updates", 0, 'h40, 0, 3, 0);
  endtask

  initial begin
    t_reset();
    t_setup();
    t_pass();
    t_faults();
    t_priority();
    t_priv();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule